// File: doc/BRIEF.md
# Windowed Watchdog Down-Counter Core

This core is a watchdog timer. Software must service it at regular intervals. When it is enabled, it loads a programmable time-out value into a down counter. The counter decrements on clock-enable pulses from one of two sources, a system tick or an oscillator tick, chosen by a select bit. A correct service sequence, reported to the core as a completion pulse, reloads the counter. Key checking, register locking and bus decoding live outside the core. The outside logic presents only two things: a strobe for every service-sequence write, and a pulse when a complete sequence has been written.

With window mode on, service is accepted only in the final part of the period, while the counter is below the window value. Any service write that arrives earlier is an invalid access. Depending on a configuration bit, the core answers it with a one-cycle bus error or with a reset request.

When the counter expires, the core either requests a reset at once or, with the interrupt-then-reset option, raises an interrupt and reloads. A second expiry before any valid service turns into a reset request. The reset request stays asserted until the core itself is reset.

Top module: `wdt_core`

## Requirements
- R1: After reset, `count` is 0 and `irq`, `rst_req` and `bus_err` are all 0.
- R2: One clock after `cfg_en` rises, `count` equals `cfg_timeout`. While `cfg_en` is 0, `count` holds, ticks are ignored, and service writes raise no fault.
- R3: With `cfg_clk_sel` = 0 only `tick_sys` advances the counter; with `cfg_clk_sel` = 1 only `tick_osc` does.
- R4: While the core is running and `count` is non-zero, each selected tick lowers `count` by exactly one, visible one clock after the tick.
- R5: A `svc_done` pulse while the window is open reloads `count` with `cfg_timeout` one clock later and clears `irq`.
- R6: With `cfg_win_en` = 1 the window is open only while `count` < `cfg_window`. With `cfg_win_en` = 0 it is always open. For example, with time-out 5000 and window 1000, service at count 1000 is refused and service at 999 is accepted.
- R7: A service write (`svc_try` or `svc_done`) while the window is closed does not reload the counter. With `cfg_bad_rst` = 0 it gives a one-cycle `bus_err` pulse on the next clock. With `cfg_bad_rst` = 1 it sets `rst_req` on the next clock.
- R8: With `cfg_irq_first` = 0, a selected tick while `count` is 0 sets `rst_req` on the next clock.
- R9: With `cfg_irq_first` = 1, the first expiry sets `irq` and reloads `count` with `cfg_timeout`. Any later expiry that comes before a valid service sets `rst_req`.
- R10: After a valid service clears `irq`, the next expiry is again treated as a first expiry and raises `irq`, not `rst_req`.
- R11: Once set, `rst_req` stays 1 until reset, and `count` no longer changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_en | input | 1 | Watchdog enable |
| cfg_win_en | input | 1 | Window mode enable |
| cfg_clk_sel | input | 1 | Tick source: 0 system, 1 oscillator |
| cfg_irq_first | input | 1 | First expiry raises an interrupt instead of a reset |
| cfg_bad_rst | input | 1 | Invalid service access: 0 bus error, 1 reset request |
| cfg_timeout | input | CNT_W | Reload value of the down counter |
| cfg_window | input | CNT_W | Window threshold |
| tick_sys | input | 1 | Clock-enable from the system clock source |
| tick_osc | input | 1 | Clock-enable from the oscillator source |
| svc_try | input | 1 | A service-sequence write occurred |
| svc_done | input | 1 | A complete, correct service sequence was written |
| irq | output | 1 | Time-out interrupt (level) |
| rst_req | output | 1 | Reset request (sticky) |
| bus_err | output | 1 | One-cycle bus error pulse |
| count | output | CNT_W | Down-counter value |

## Verification
Service pulses are issued at count 1000 and at 999 under a 5000/1000 window, which pins the strict less-than edge of the window. The same service with window mode off checks that the window is always open. Invalid writes are repeated with each invalid-access action, to show bus error against reset request. The counter is run to expiry with interrupt-then-reset off, with it on but never serviced, and with it on plus a service between expiries. These three runs separate an immediate reset, a reset on the second expiry, and the re-arming of the interrupt. Ticks are also sent on the unselected source and while the core is disabled, to confirm that neither moves the counter.

// File: rtl/wdt_pkg.sv
// Package: shared types of the watchdog core.
// Assumes nothing beyond IEEE 1800-2017 packages.
package wdt_pkg;

    // Supervisor state: off, armed, warned (irq pending), tripped (reset requested)
    typedef enum logic [1:0] {
        WD_OFF     = 2'd0,
        WD_ARMED   = 2'd1,
        WD_WARNED  = 2'd2,
        WD_TRIPPED = 2'd3
    } wd_state_t;

    // Number of tick sources feeding the counter
    localparam int unsigned WD_N_SRC = 2;

endpackage

// File: rtl/wdt_tick_sel.sv
// Module: wdt_tick_sel
// Picks one of N_SRC clock-enable strobes as the counter tick.
// Assumes every strobe is already synchronous to clk and one cycle wide per event.
module wdt_tick_sel #(
    parameter int unsigned N_SRC = 2,
    localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0] ticks,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);

    // Source mux: an out-of-range select gives no tick
    always_comb begin
        tick = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (sel == SEL_W'(i)) tick = ticks[i];
        end
    end

endmodule

// File: rtl/wdt_window.sv
// Module: wdt_window
// Decides whether a service write lands in the open window and classifies it.
// Assumes 'running' is low whenever the watchdog is off or has tripped.
module wdt_window #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             running,
    input  logic             win_en,
    input  logic [CNT_W-1:0] count,
    input  logic [CNT_W-1:0] window,
    input  logic             svc_try,
    input  logic             svc_done,
    output logic             svc_reload,
    output logic             svc_bad
);

    logic open_w;
    logic any_write;

    // Window test and service classification
    always_comb begin
        open_w     = !win_en || (count < window);
        any_write  = svc_try || svc_done;
        svc_reload = running && svc_done && open_w;
        svc_bad    = running && any_write && !open_w;
    end

endmodule

// File: rtl/wdt_counter.sv
// Module: wdt_counter
// Down counter that loads a time-out value and steps down by one on each decrement request.
// Assumes the caller never asks for load and decrement in the same cycle.
module wdt_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             dec,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             zero
);

    // Count register: load wins, otherwise step down when asked
    always_ff @(posedge clk) begin
        if (!rst_n)    count <= '0;
        else if (load) count <= load_val;
        else if (dec)  count <= count - CNT_W'(1);
    end

    // Zero flag for expiry detection
    always_comb zero = (count == '0);

endmodule

// File: rtl/wdt_supervisor.sv
// Module: wdt_supervisor
// Holds the watchdog state. Decides on reloads and turns expiries and bad
// service writes into irq, reset request or bus error.
// Assumes svc_reload and svc_bad are already gated by 'running' from this module.
module wdt_supervisor
    import wdt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic irq_first,
    input  logic bad_rst,
    input  logic tick,
    input  logic zero,
    input  logic svc_reload,
    input  logic svc_bad,
    output logic running,
    output logic load,
    output logic dec,
    output logic irq,
    output logic rst_req,
    output logic bus_err
);

    wd_state_t state, state_nx;
    logic      start;
    logic      expire;
    logic      warn;
    logic      trip;

    // Event decode for this cycle
    always_comb begin
        start   = en && (state == WD_OFF);
        running = en && ((state == WD_ARMED) || (state == WD_WARNED));
        expire  = running && tick && zero && !svc_reload;
        warn    = expire && irq_first && (state == WD_ARMED);
        trip    = (expire && !warn) || (svc_bad && bad_rst);
        load    = start || svc_reload || warn;
        dec     = running && tick && !zero && !svc_reload;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        if (state == WD_TRIPPED) state_nx = WD_TRIPPED;
        else if (trip)           state_nx = WD_TRIPPED;
        else if (!en)            state_nx = WD_OFF;
        else if (start)          state_nx = WD_ARMED;
        else if (svc_reload)     state_nx = WD_ARMED;
        else if (warn)           state_nx = WD_WARNED;
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= WD_OFF;
        else        state <= state_nx;
    end

    // Bus error pulse register
    always_ff @(posedge clk) begin
        if (!rst_n) bus_err <= 1'b0;
        else        bus_err <= svc_bad && !bad_rst;
    end

    // Outputs derived from the state
    always_comb begin
        irq     = (state == WD_WARNED);
        rst_req = (state == WD_TRIPPED);
    end

endmodule

// File: rtl/wdt_core.sv
// Module: wdt_core (top)
// Windowed watchdog: a tick-source mux, a window classifier, the down counter
// and the supervisor state machine.
// Assumes ticks and service strobes are synchronous single-cycle pulses.
module wdt_core
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_win_en,
    input  logic             cfg_clk_sel,
    input  logic             cfg_irq_first,
    input  logic             cfg_bad_rst,
    input  logic [CNT_W-1:0] cfg_timeout,
    input  logic [CNT_W-1:0] cfg_window,
    input  logic             tick_sys,
    input  logic             tick_osc,
    input  logic             svc_try,
    input  logic             svc_done,
    output logic             irq,
    output logic             rst_req,
    output logic             bus_err,
    output logic [CNT_W-1:0] count
);

    logic tick;
    logic zero;
    logic running;
    logic load;
    logic dec;
    logic svc_reload;
    logic svc_bad;

    wdt_tick_sel #(.N_SRC(WD_N_SRC)) u_tick_sel (
        .ticks ({tick_osc, tick_sys}),
        .sel   (cfg_clk_sel),
        .tick  (tick)
    );

    wdt_window #(.CNT_W(CNT_W)) u_window (
        .running    (running),
        .win_en     (cfg_win_en),
        .count      (count),
        .window     (cfg_window),
        .svc_try    (svc_try),
        .svc_done   (svc_done),
        .svc_reload (svc_reload),
        .svc_bad    (svc_bad)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .dec      (dec),
        .load_val (cfg_timeout),
        .count    (count),
        .zero     (zero)
    );

    wdt_supervisor u_supervisor (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cfg_en),
        .irq_first  (cfg_irq_first),
        .bad_rst    (cfg_bad_rst),
        .tick       (tick),
        .zero       (zero),
        .svc_reload (svc_reload),
        .svc_bad    (svc_bad),
        .running    (running),
        .load       (load),
        .dec        (dec),
        .irq        (irq),
        .rst_req    (rst_req),
        .bus_err    (bus_err)
    );

endmodule

// File: rtl/wdt_core_chk.sv
// Module: wdt_core_chk
// Port-level properties of wdt_core, attached with bind.
module wdt_core_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_en,
    input logic [CNT_W-1:0] cfg_timeout,
    input logic             svc_try,
    input logic             svc_done,
    input logic             irq,
    input logic             rst_req,
    input logic             bus_err,
    input logic [CNT_W-1:0] count
);

    // R2
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_en && $past(!cfg_en)) |-> (count == $past(count)));

    // R4
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != $past(count)) |-> ((count == $past(count) - CNT_W'(1)) || (count == $past(cfg_timeout))));

    // R7
    bus_err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> $past(svc_try || svc_done));

    // R9
    irq_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(count) == '0));

    // R11
    rst_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> (rst_req && $stable(count)));

    // R1
    always @(posedge clk) begin
        if (!rst_n && $past(!rst_n)) begin
            reset_state_chk: assert (count == '0 && !irq && !rst_req && !bus_err);
        end
    end

endmodule

bind wdt_core wdt_core_chk #(.CNT_W(CNT_W)) u_wdt_core_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_en      (cfg_en),
    .cfg_timeout (cfg_timeout),
    .svc_try     (svc_try),
    .svc_done    (svc_done),
    .irq         (irq),
    .rst_req     (rst_req),
    .bus_err     (bus_err),
    .count       (count)
);

// File: tb/test_wdt_core.sv
module test_wdt_core;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cfg_en, cfg_win_en, cfg_clk_sel, cfg_irq_first, cfg_bad_rst;
    logic [CNT_W-1:0] cfg_timeout, cfg_window;
    logic             tick_sys, tick_osc, svc_try, svc_done;
    logic             irq, rst_req, bus_err;
    logic [CNT_W-1:0] count;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    wdt_core #(.CNT_W(CNT_W)) i_wdt_core (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_win_en(cfg_win_en),
        .cfg_clk_sel(cfg_clk_sel), .cfg_irq_first(cfg_irq_first), .cfg_bad_rst(cfg_bad_rst),
        .cfg_timeout(cfg_timeout), .cfg_window(cfg_window), .tick_sys(tick_sys),
        .tick_osc(tick_osc), .svc_try(svc_try), .svc_done(svc_done),
        .irq(irq), .rst_req(rst_req), .bus_err(bus_err), .count(count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input int tmo, input int win, input bit wen, input bit itr, input bit brst);
        rst_n = 1'b0; cfg_en = 1'b0; cfg_win_en = wen; cfg_clk_sel = 1'b0;
        cfg_irq_first = itr; cfg_bad_rst = brst;
        cfg_timeout = CNT_W'(tmo); cfg_window = CNT_W'(win);
        tick_sys = 1'b0; tick_osc = 1'b0; svc_try = 1'b0; svc_done = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
    endtask

    task automatic ticks(input int n, input bit osc);
        if (osc) tick_osc = 1'b1; else tick_sys = 1'b1;
        repeat (n) step();
        tick_osc = 1'b0; tick_sys = 1'b0;
    endtask

    task automatic service(input bit full);
        if (full) svc_done = 1'b1; else svc_try = 1'b1;
        step();
        svc_done = 1'b0; svc_try = 1'b0;
    endtask

    task automatic t_reset();
        do_reset(20, 0, 0, 0, 0);
        check("R1 count", int'(count), 0);
        check("R1 irq/rst/berr", int'({irq, rst_req, bus_err}), 0);
    endtask

    task automatic t_enable();
        do_reset(20, 0, 0, 0, 0);
        ticks(3, 0);
        check("R2 disabled count holds", int'(count), 0);
        service(0);
        check("R2 no fault when disabled", int'({rst_req, bus_err}), 0);
        cfg_en = 1'b1; step();
        check("R2 load on enable", int'(count), 20);
        ticks(5, 0);
        check("R4 decrement by ticks", int'(count), 15);
        cfg_en = 1'b0; step();
        ticks(3, 0);
        check("R2 hold while disabled", int'(count), 15);
        cfg_en = 1'b1; step();
        check("R2 reload on re-enable", int'(count), 20);
    endtask

    task automatic t_clksel();
        do_reset(20, 0, 0, 0, 0);
        cfg_en = 1'b1; step();
        ticks(2, 1);
        check("R3 osc ignored when sel=0", int'(count), 20);
        ticks(2, 0);
        check("R3 sys counts when sel=0", int'(count), 18);
        cfg_clk_sel = 1'b1;
        ticks(3, 0);
        check("R3 sys ignored when sel=1", int'(count), 18);
        ticks(4, 1);
        check("R3 osc counts when sel=1", int'(count), 14);
    endtask

    task automatic t_window();
        do_reset(5000, 1000, 1, 0, 0);
        cfg_en = 1'b1; step();
        ticks(4000, 0);
        check("R6 at boundary", int'(count), 1000);
        service(1);
        check("R7 bus_err on early service", int'(bus_err), 1);
        check("R7 no reload when closed", int'(count), 1000);
        check("R7 no reset with bus error action", int'(rst_req), 0);
        step();
        check("R7 bus_err one cycle", int'(bus_err), 0);
        ticks(1, 0);
        service(1);
        check("R6 accepted inside window", int'(count), 5000);
        check("R5 no bus_err in window", int'(bus_err), 0);
        cfg_win_en = 1'b0;
        ticks(10, 0);
        service(1);
        check("R6 window off always open", int'(count), 5000);
    endtask

    task automatic t_bad_reset();
        do_reset(100, 10, 1, 0, 1);
        cfg_en = 1'b1; step();
        service(0);
        check("R7 reset action", int'(rst_req), 1);
        check("R7 no bus_err with reset action", int'(bus_err), 0);
        ticks(5, 0);
        service(1);
        check("R11 rst sticky", int'(rst_req), 1);
        check("R11 count frozen", int'(count), 100);
    endtask

    task automatic t_timeout_reset();
        do_reset(3, 0, 0, 0, 0);
        cfg_en = 1'b1; step();
        ticks(3, 0);
        check("R8 no reset at zero yet", int'(rst_req), 0);
        ticks(1, 0);
        check("R8 reset on expiry", int'(rst_req), 1);
        check("R8 no irq", int'(irq), 0);
    endtask

    task automatic t_irq_then_reset();
        do_reset(3, 0, 0, 1, 0);
        cfg_en = 1'b1; step();
        ticks(4, 0);
        check("R9 irq on first expiry", int'(irq), 1);
        check("R9 reload on first expiry", int'(count), 3);
        check("R9 no reset on first expiry", int'(rst_req), 0);
        service(1);
        check("R5 service clears irq", int'(irq), 0);
        check("R5 service reloads", int'(count), 3);
        ticks(4, 0);
        check("R10 irq again after service", int'(irq), 1);
        check("R10 still no reset", int'(rst_req), 0);
        ticks(4, 0);
        check("R9 second expiry resets", int'(rst_req), 1);
    endtask

    initial begin
        t_reset();
        t_enable();
        t_clksel();
        t_window();
        t_bad_reset();
        t_timeout_reset();
        t_irq_then_reset();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule